// File: doc/BRIEF.md
# Banked Register Window Sequencer

This block connects a simple request/response host port to a 16-bit device register bus. The device bus exposes only eight word slots. The highest slot holds a 3-bit bank selector, which decides which bank of registers the other seven slots reach. A host request names a logical register with a 7-bit number. The upper three bits of that number are the bank, and the lower four bits are a byte offset within the bank. The data slot is the byte offset halved.

A banked request runs as one indivisible device sequence:

1. Read the selector slot and keep the bank it reports.
2. Write the target bank into the selector slot.
3. Perform the requested read or write on the data slot.
4. Write the kept bank back into the selector slot.

The host port stays closed for the whole sequence, so no other request can interleave with it. A fast request skips all bank handling. It performs a single access to the computed slot in whatever bank is currently selected. A fast access to slot 7 therefore changes the selector directly.

Device read data arrives one cycle after the read strobe. Each request ends with a one-cycle done pulse, which carries the read word for reads.

Top module: `bank_window_seq`

## Requirements
- R1: While reset is held and on the first cycle after it, req_ready is 1, and rsp_done, dev_we and dev_re are 0.
- R2: The target bank is req_reg[6:4] and the data slot is req_reg[3:1]. Bit 0 of req_reg has no effect, so an odd offset reaches the same slot as the even offset below it.
- R3: A banked request drives exactly four consecutive device cycles, in this order:
  - a read of slot 7;
  - a write of the target bank to slot 7;
  - the requested read or write on the data slot;
  - a write to slot 7 of the bank that the first read returned.
- R4: Every slot-7 write made by a banked sequence has bits 15:3 equal to zero. Only bits 2:0 of the word read from slot 7 are kept.
- R5: After a banked request completes, the selector in slot 7 holds the same bank as before the request.
- R6: req_ready is 0 from the cycle after a request is accepted until the cycle in which rsp_done is high. A request waiting on the port starts its first device cycle only after the previous restore write.
- R7: A fast request drives exactly one device cycle, on the computed slot, with no save, select or restore.
- R8: For a read, the word the device returns (sampled one cycle after dev_re) appears on rsp_rdata while rsp_done is high. A banked read returns the word from the target bank. A fast read returns the word from the current bank.
- R9: Each request produces one rsp_done pulse, one cycle long. Counting cycles after the acceptance edge, the pulse comes in:
  - the fifth cycle for a banked request;
  - the third cycle for a fast read;
  - the second cycle for a fast write.
- R10: A banked write changes only the addressed slot of the target bank. The same slot in the current bank keeps its value.
- R11: dev_we and dev_re are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Sequencer can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_fast | input | 1 | 1 = access the current bank with no bank handling |
| req_reg | input | 7 | Logical register: bank in 6:4, byte offset in 3:0 |
| req_wdata | input | 16 | Write data |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 16 | Read data, valid with rsp_done |
| dev_addr | output | 3 | Device word slot |
| dev_we | output | 1 | Device write strobe |
| dev_wdata | output | 16 | Device write data |
| dev_re | output | 1 | Device read strobe |
| dev_rdata | input | 16 | Device read data, one cycle after dev_re |

## Verification
The first banked access starts with junk in the upper bits of the selector word. A design that saved the whole word would restore that junk instead of zeros. The bench also holds a second request on the port during a banked sequence. A design that reopened the port early would place the new request's device cycle ahead of the restore write. Banked reads and writes are aimed at a bank other than the current one, and odd offsets are used. This exposes a design that left the target unselected, wrote to the wrong bank, restored the wrong bank, or kept address bit 0. Fast accesses to both the selector slot and a data slot show whether any bank handling leaks into the fast path.

// File: rtl/bank_window_seq.sv
module bank_window_seq #(
  parameter int DW = 16,
  parameter int RW = 7,
  parameter int BW = 3,
  parameter int SW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic          req_fast,
  input  logic [RW-1:0] req_reg,
  input  logic [DW-1:0] req_wdata,
  output logic          rsp_done,
  output logic [DW-1:0] rsp_rdata,
  output logic [SW-1:0] dev_addr,
  output logic          dev_we,
  output logic [DW-1:0] dev_wdata,
  output logic          dev_re,
  input  logic [DW-1:0] dev_rdata
);

  localparam int OFF_HI = RW - BW - 1;
  localparam logic [SW-1:0] SEL_SLOT = '1;

  typedef enum logic [2:0] {
    ST_IDLE, ST_SAVE, ST_SEL, ST_ACC, ST_REST, ST_FACC, ST_FRD
  } state_t;

  state_t        state;
  logic          wr_q, fast_q;
  logic [BW-1:0] bank_q, saved_q;
  logic [SW-1:0] slot_q;
  logic [DW-1:0] wdata_q;
  logic          unused_bit0;

  assign unused_bit0 = req_reg[0];

  wire accept   = req_valid && req_ready;
  wire in_bank  = (state == ST_SAVE) || (state == ST_SEL) || (state == ST_REST);
  wire in_acc   = (state == ST_ACC) || (state == ST_FACC);
  wire finish   = (state == ST_REST) || (state == ST_FRD) ||
                  ((state == ST_FACC) && wr_q);
  wire take_rd  = ((state == ST_REST) && !wr_q) || (state == ST_FRD);

  assign req_ready = (state == ST_IDLE);
  assign dev_re    = (state == ST_SAVE) || (in_acc && !wr_q);
  assign dev_we    = (state == ST_SEL) || (state == ST_REST) || (in_acc && wr_q);
  assign dev_addr  = in_bank ? SEL_SLOT : slot_q;
  assign dev_wdata = (state == ST_SEL)  ? {{(DW-BW){1'b0}}, bank_q}  :
                     (state == ST_REST) ? {{(DW-BW){1'b0}}, saved_q} : wdata_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      wr_q      <= 1'b0;
      fast_q    <= 1'b0;
      bank_q    <= '0;
      saved_q   <= '0;
      slot_q    <= '0;
      wdata_q   <= '0;
      rsp_done  <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_done <= finish;
      if (take_rd) rsp_rdata <= dev_rdata;
      unique case (state)
        ST_IDLE: if (accept) begin
          wr_q    <= req_write;
          fast_q  <= req_fast;
          bank_q  <= req_reg[RW-1:RW-BW];
          slot_q  <= req_reg[OFF_HI:1];
          wdata_q <= req_wdata;
          state   <= req_fast ? ST_FACC : ST_SAVE;
        end
        ST_SAVE: state <= ST_SEL;
        ST_SEL: begin
          saved_q <= dev_rdata[BW-1:0];
          state   <= ST_ACC;
        end
        ST_ACC:  state <= ST_REST;
        ST_REST: state <= ST_IDLE;
        ST_FACC: state <= wr_q ? ST_IDLE : ST_FRD;
        ST_FRD:  state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/bank_window_seq_chk.sv
module bank_window_seq_chk #(
  parameter int DW = 16,
  parameter int BW = 3,
  parameter int SW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic          rsp_done,
  input logic [SW-1:0] dev_addr,
  input logic          dev_we,
  input logic [DW-1:0] dev_wdata,
  input logic          dev_re,
  input logic [DW-1:0] dev_rdata,
  input logic          fast_q,
  input logic          in_save,
  input logic          in_rest
);

  localparam logic [SW-1:0] SEL_SLOT = '1;

  logic          ck_pend;
  logic [BW-1:0] ck_saved;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ck_pend  <= 1'b0;
      ck_saved <= '0;
    end else begin
      ck_pend <= in_save;
      if (ck_pend) ck_saved <= dev_rdata[BW-1:0];
    end
  end

  AST_RW_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(dev_we && dev_re)); // R11

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done); // R9

  AST_LOCKED_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready); // R6

  AST_SELECT_FOLLOWS_SAVE: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_re && dev_addr == SEL_SLOT && !fast_q) |=>
      (dev_we && dev_addr == SEL_SLOT && dev_wdata[DW-1:BW] == '0)); // R3

  AST_RESTORE_SAVED: assert property (@(posedge clk) disable iff (!rst_n)
    in_rest |-> (dev_we && dev_addr == SEL_SLOT &&
                 dev_wdata == {{(DW-BW){1'b0}}, ck_saved})); // R5

  AST_DONE_AFTER_RESTORE: assert property (@(posedge clk) disable iff (!rst_n)
    in_rest |=> rsp_done); // R9

endmodule

bind bank_window_seq bank_window_seq_chk #(.DW(DW), .BW(BW), .SW(SW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .rsp_done(rsp_done), .dev_addr(dev_addr), .dev_we(dev_we),
  .dev_wdata(dev_wdata), .dev_re(dev_re), .dev_rdata(dev_rdata),
  .fast_q(fast_q), .in_save(state == ST_SAVE), .in_rest(state == ST_REST)
);

// File: tb/sim_bank_window_seq.sv
module sim_bank_window_seq;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, req_valid, req_ready, req_write, req_fast, rsp_done, dev_we, dev_re;
  logic [6:0] req_reg;
  logic [15:0] req_wdata, rsp_rdata, dev_wdata, dev_rdata;
  logic [2:0] dev_addr;

  bank_window_seq u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_fast(req_fast), .req_reg(req_reg),
    .req_wdata(req_wdata), .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
    .dev_addr(dev_addr), .dev_we(dev_we), .dev_wdata(dev_wdata),
    .dev_re(dev_re), .dev_rdata(dev_rdata)
  );

  int total = 0, bad = 0, ovl = 0, log_n = 0;
  logic [15:0] dmem [0:63];
  logic [15:0] expm [0:63];
  logic [15:0] slot7;
  logic        log_we [0:127];
  logic [2:0]  log_a  [0:127];
  logic [15:0] log_d  [0:127];

  always @(posedge clk) begin
    if (dev_we && dev_re) ovl++;
    if ((dev_we || dev_re) && log_n < 128) begin
      log_we[log_n] <= dev_we;
      log_a[log_n]  <= dev_addr;
      log_d[log_n]  <= dev_wdata;
    end
    if (dev_we || dev_re) log_n++;
    if (dev_we) begin
      if (dev_addr == 3'd7) slot7 <= dev_wdata;
      else dmem[{slot7[2:0], dev_addr}] <= dev_wdata;
    end
    if (dev_re) dev_rdata <= (dev_addr == 3'd7) ? slot7 : dmem[{slot7[2:0], dev_addr}];
  end

  task automatic chk(input bit ok, input string rq, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  task automatic chk_op(input int idx, input bit we, input logic [2:0] a,
                        input logic [15:0] d, input string rq);
    chk(log_we[idx] == we, rq, "op kind", int'(log_we[idx]), int'(we));
    chk(log_a[idx] == a, rq, "op slot", int'(log_a[idx]), int'(a));
    if (we) chk(log_d[idx] == d, rq, "op data", int'(log_d[idx]), int'(d));
  endtask

  task automatic do_req(input bit wr, input bit fast, input logic [6:0] r,
                        input logic [15:0] wd, output logic [15:0] rd, output int lat);
    int open_cnt = 0;
    @(negedge clk);
    req_valid = 1; req_write = wr; req_fast = fast; req_reg = r; req_wdata = wd;
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
    lat = 1;
    while (!rsp_done && lat < 20) begin
      if (req_ready) open_cnt++;
      @(negedge clk);
      lat++;
    end
    rd = rsp_rdata;
    chk(open_cnt == 0, "R6", "ready while busy", open_cnt, 0);
    @(negedge clk);
    chk(rsp_done == 0, "R9", "done width", int'(rsp_done), 0);
  endtask

  task automatic t_reset;
    chk(req_ready == 1, "R1", "ready", int'(req_ready), 1);
    chk(rsp_done == 0, "R1", "done", int'(rsp_done), 0);
    chk(dev_we == 0 && dev_re == 0, "R1", "strobes", int'({dev_we, dev_re}), 0);
  endtask

  task automatic t_banked_read_masks;
    logic [15:0] rd; int lat; int b = log_n;
    do_req(0, 0, 7'h56, 16'h0, rd, lat);
    chk(lat == 5, "R9", "banked latency", lat, 5);
    chk(log_n - b == 4, "R3", "op count", log_n - b, 4);
    chk_op(b, 0, 3'd7, 16'h0, "R3");
    chk_op(b + 1, 1, 3'd7, 16'h0005, "R3");
    chk_op(b + 2, 0, 3'd3, 16'h0, "R2");
    chk_op(b + 3, 1, 3'd7, 16'h0000, "R4");
    chk(rd == expm[5*8+3], "R8", "banked read", int'(rd), int'(expm[5*8+3]));
    do_req(0, 1, 7'h0E, 16'h0, rd, lat);
    chk(rd == 16'h0000, "R5", "bank after read", int'(rd), 0);
  endtask

  task automatic t_fast_path;
    logic [15:0] rd; int lat; int b = log_n;
    do_req(1, 1, 7'h0F, 16'h0002, rd, lat);
    chk(lat == 2, "R9", "fast write latency", lat, 2);
    chk(log_n - b == 1, "R7", "fast write ops", log_n - b, 1);
    chk_op(b, 1, 3'd7, 16'h0002, "R7");
    b = log_n;
    do_req(0, 1, 7'h05, 16'h0, rd, lat);
    chk(lat == 3, "R9", "fast read latency", lat, 3);
    chk(log_n - b == 1, "R7", "fast read ops", log_n - b, 1);
    chk_op(b, 0, 3'd2, 16'h0, "R7");
    chk(rd == expm[2*8+2], "R8", "fast read", int'(rd), int'(expm[2*8+2]));
  endtask

  task automatic t_banked_write;
    logic [15:0] rd; int lat; int b = log_n;
    do_req(1, 0, 7'h19, 16'hCAFE, rd, lat);
    expm[1*8+4] = 16'hCAFE;
    chk(log_n - b == 4, "R3", "write op count", log_n - b, 4);
    chk_op(b, 0, 3'd7, 16'h0, "R3");
    chk_op(b + 1, 1, 3'd7, 16'h0001, "R4");
    chk_op(b + 2, 1, 3'd4, 16'hCAFE, "R2");
    chk_op(b + 3, 1, 3'd7, 16'h0002, "R5");
    do_req(0, 1, 7'h08, 16'h0, rd, lat);
    chk(rd == expm[2*8+4], "R10", "current bank untouched", int'(rd), int'(expm[2*8+4]));
    do_req(0, 0, 7'h18, 16'h0, rd, lat);
    chk(rd == 16'hCAFE, "R10", "target written", int'(rd), 16'hCAFE);
    do_req(0, 1, 7'h0E, 16'h0, rd, lat);
    chk(rd == 16'h0002, "R5", "bank after write", int'(rd), 2);
  endtask

  task automatic t_atomic_hold;
    logic [15:0] rda, rdb; int n = 0; int b = log_n;
    @(negedge clk);
    req_valid = 1; req_write = 0; req_fast = 0; req_reg = 7'h71; req_wdata = 0;
    @(posedge clk);
    @(negedge clk);
    req_fast = 1; req_reg = 7'h02;
    while (!rsp_done && n < 20) begin @(negedge clk); n++; end
    rda = rsp_rdata;
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
    n = 0;
    while (!rsp_done && n < 20) begin @(negedge clk); n++; end
    rdb = rsp_rdata;
    chk(log_n - b == 5, "R6", "ops for two requests", log_n - b, 5);
    chk_op(b + 3, 1, 3'd7, 16'h0002, "R6");
    chk_op(b + 4, 0, 3'd1, 16'h0, "R6");
    chk(rda == expm[7*8+0], "R8", "held banked read", int'(rda), int'(expm[56]));
    chk(rdb == expm[2*8+1], "R8", "queued fast read", int'(rdb), int'(expm[17]));
    @(negedge clk);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 5000, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) begin
      dmem[i] = 16'h1000 + 16'(i) * 16'h0111;
      expm[i] = 16'h1000 + 16'(i) * 16'h0111;
    end
    slot7 = 16'hBEE8;
    dev_rdata = 16'h0;
    rst_n = 0; req_valid = 0; req_write = 0; req_fast = 0; req_reg = 0; req_wdata = 0;
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_banked_read_masks;
    t_fast_path;
    t_banked_write;
    t_atomic_hold;
    chk(ovl == 0, "R11", "read and write overlap", ovl, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule